// File: doc/BRIEF.md
# Receiver front-end control and status register bank

This block is the register file that sits between a serial control-bus engine and the signal-processing datapath of a television IF receiver front-end. The bus engine presents single-cycle write and read strobes with a 16-bit address and 16-bit data. The bank holds the configuration that the datapath consumes: broadcast standard, output levels, reference divider, preamplifier gain, a six-pin general-purpose output port and four group-delay equalizer coefficients. It also returns measurement values that the datapath produces.

Equalizer coefficients are written into a shadow set. They move to the active set, which the datapath sees, only on an explicit commit, so a filter never runs with a half-updated coefficient set. A control word provides a software reset and two sticky flags. One flag records that a reset has happened and the other records an internal error. Reading the control word clears both flags.

The default of the reference divider follows a strap input, so the clock synthesizer starts correctly for either crystal family without any bus traffic.

Top module: `rxfe_csr_bank`

## Requirements
- R1: After rst_n is held low for at least one rising edge, the outputs are std_sel=0x103, lvl_cfg=0x000, top_gain=0x3, port_pins=0x00, and coef_active holds 0x025, 0x197, 0x0C5 and 0x12E for coefficients 0 to 3 (coefficient i in bits 9i+8 to 9i).
- R2: The reference divider default is 0x10D when strap_hi is 1 and 0x0CA when strap_hi is 0, sampled at the edge that applies a reset or a software reset.
- R3: A read of address 0x0000 returns the reset-occurred flag in bit 15, the error flag in bit 14 and zero in bits 13:0. The reset-occurred flag is 1 after power-on. A one-cycle pulse on err_evt sets the error flag, and it stays set.
- R4: A read of 0x0000 with rd_en high clears both flags at that clock edge. A flag-setting event in the same cycle wins over the clear.
- R5: A write of 0x0000 with wdata bit 15 set starts a software reset. At the following edge every write register, including the port and both coefficient sets, returns to its default, the reset-occurred flag sets, and any write presented in that cycle is discarded. A write of 0x0000 with bit 15 clear has no effect.
- R6: Writes take effect at the strobe's clock edge, and data bits above each register's width are ignored. The registers are: 0x0020 std_sel (bits 11:0), 0x1001 lvl_cfg (bits 9:0), 0x1010 ref_div (bits 8:0) and 0x1012 top_gain (bits 3:0).
- R7: A write to 0x0003 sets port_pins from wdata bits 5:0. The port register reads back as zero.
- R8: Writes to 0x1071 to 0x1073 stage coefficients 1 to 3 from bits 8:0. A write to 0x1070 stages coefficient 0 from bits 9:1. When bit 0 of that write is 1, all four staged values, including the one just written, are copied to coef_active at the same edge. Otherwise coef_active is unchanged.
- R9: Status reads return zero-extended values: 0x1005 st_gain (11 bits), 0x1006 st_tuner (12 bits), 0x100A st_sif (11 bits), 0x100B st_freq in bits 8:1 with st_lock in bit 0, and 0x100C st_qual (11 bits).
- R10: A write to a status address or an unmapped address changes no output and no flag. A read of any address other than 0x0000 and the five status addresses returns zero, and this includes the write-only registers.
- R11: rdata is a combinational function of addr and the current state, valid in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hi | input | 1 | Strap selecting the reference divider default |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, used for clear-on-read |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| err_evt | input | 1 | Internal error event from the datapath |
| st_gain | input | 11 | Video gain measurement |
| st_tuner | input | 12 | Tuner control current measurement |
| st_sif | input | 11 | Sound IF gain measurement |
| st_freq | input | 8 | Carrier frequency offset |
| st_lock | input | 1 | Carrier lock flag |
| st_qual | input | 11 | Lock quality measurement |
| std_sel | output | 12 | Broadcast standard selection |
| lvl_cfg | output | 10 | Peaking, sound reference and video amplitude settings |
| ref_div | output | 9 | Reference divider |
| top_gain | output | 4 | Preamplifier gain setting |
| coef_active | output | 36 | Active equalizer coefficients, 9 bits each |
| port_pins | output | 6 | General-purpose output pins |

## Verification
On every cycle, the assertions check that the flags behave as clear-on-read and sticky, and that a pending software reset restores the defaults together with the strap-selected divider. They also check that the port pins and the active coefficient set hold still unless their own commit occurs, and that reads outside the readable map return zero. Some behaviours can only be shown by the bench's scenarios: that a staged value travels to the datapath only with a commit, that writes to every unmapped address in the two populated address pages are ignored, that a full sweep of the read space packs each status field correctly, and that a write arriving during the restore cycle is lost.

// File: rtl/rxfe_csr_pkg.sv
package rxfe_csr_pkg;

    localparam logic [15:0] ADR_CTRL   = 16'h0000;
    localparam logic [15:0] ADR_PORT   = 16'h0003;
    localparam logic [15:0] ADR_STD    = 16'h0020;
    localparam logic [15:0] ADR_LVL    = 16'h1001;
    localparam logic [15:0] ADR_REFDIV = 16'h1010;
    localparam logic [15:0] ADR_TOP    = 16'h1012;
    localparam logic [15:0] ADR_COEF0  = 16'h1070;
    localparam logic [15:0] ADR_GAIN   = 16'h1005;
    localparam logic [15:0] ADR_TUNER  = 16'h1006;
    localparam logic [15:0] ADR_SIF    = 16'h100A;
    localparam logic [15:0] ADR_FREQ   = 16'h100B;
    localparam logic [15:0] ADR_QUAL   = 16'h100C;

    localparam logic [15:0] DEF_STD       = 16'h0103;
    localparam logic [15:0] DEF_LVL       = 16'h0000;
    localparam logic [15:0] DEF_TOP       = 16'h0003;
    localparam logic [15:0] DEF_PORT      = 16'h0000;
    localparam logic [15:0] DEF_REF_HIGH  = 16'h010D;
    localparam logic [15:0] DEF_REF_LOW   = 16'h00CA;

    typedef struct packed {
        logic ctrl;
        logic port;
        logic std;
        logic lvl;
        logic refdiv;
        logic top;
    } wsel_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_GAIN,
        RSEL_TUNER,
        RSEL_SIF,
        RSEL_FREQ,
        RSEL_QUAL
    } rsel_e;

    function automatic logic [15:0] coef_default(input int idx);
        case (idx)
            0:       coef_default = 16'h0025;
            1:       coef_default = 16'h0197;
            2:       coef_default = 16'h00C5;
            3:       coef_default = 16'h012E;
            default: coef_default = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rxfe_csr_decode.sv
module rxfe_csr_decode
    import rxfe_csr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_COEF = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output wsel_t               wsel,
    output logic [NUM_COEF-1:0] coef_sel,
    output rsel_e               rsel
);

    always_comb begin
        wsel        = '0;
        wsel.ctrl   = (addr == ADDR_W'(ADR_CTRL));
        wsel.port   = (addr == ADDR_W'(ADR_PORT));
        wsel.std    = (addr == ADDR_W'(ADR_STD));
        wsel.lvl    = (addr == ADDR_W'(ADR_LVL));
        wsel.refdiv = (addr == ADDR_W'(ADR_REFDIV));
        wsel.top    = (addr == ADDR_W'(ADR_TOP));
    end

    for (genvar gi = 0; gi < NUM_COEF; gi++) begin : g_coef_dec
        localparam logic [ADDR_W-1:0] COEF_ADR = ADDR_W'(ADR_COEF0) + ADDR_W'(gi);
        assign coef_sel[gi] = (addr == COEF_ADR);
    end

    always_comb begin
        if (addr == ADDR_W'(ADR_CTRL))       rsel = RSEL_CTRL;
        else if (addr == ADDR_W'(ADR_GAIN))  rsel = RSEL_GAIN;
        else if (addr == ADDR_W'(ADR_TUNER)) rsel = RSEL_TUNER;
        else if (addr == ADDR_W'(ADR_SIF))   rsel = RSEL_SIF;
        else if (addr == ADDR_W'(ADR_FREQ))  rsel = RSEL_FREQ;
        else if (addr == ADDR_W'(ADR_QUAL))  rsel = RSEL_QUAL;
        else                                 rsel = RSEL_NONE;
    end

endmodule

// File: rtl/rxfe_csr_coef.sv
module rxfe_csr_coef
    import rxfe_csr_pkg::*;
#(
    parameter int NUM_COEF = 4,
    parameter int COEF_W   = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restore,
    input  logic                         wr_en,
    input  logic [NUM_COEF-1:0]          coef_sel,
    input  logic [COEF_W:0]              wval,
    output logic [NUM_COEF*COEF_W-1:0]   coef_active
);

    typedef struct packed {
        logic [NUM_COEF-1:0][COEF_W-1:0] stage;
        logic [NUM_COEF-1:0][COEF_W-1:0] act;
    } coef_t;

    coef_t s_d, s_q;

    function automatic coef_t coef_reset();
        coef_t r;
        for (int i = 0; i < NUM_COEF; i++) begin
            r.stage[i] = COEF_W'(coef_default(i));
            r.act[i]   = COEF_W'(coef_default(i));
        end
        return r;
    endfunction

    always_comb begin
        s_d = s_q;
        if (restore) begin
            s_d = coef_reset();
        end else if (wr_en) begin
            for (int i = 0; i < NUM_COEF; i++) begin
                if (coef_sel[i]) begin
                    // coefficient 0 shares its word with the commit bit
                    s_d.stage[i] = (i == 0) ? wval[COEF_W:1] : wval[COEF_W-1:0];
                end
            end
            if (coef_sel[0] && wval[0]) begin
                s_d.act = s_d.stage;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= coef_reset();
        else        s_q <= s_d;
    end

    assign coef_active = s_q.act;

endmodule

// File: rtl/rxfe_csr_ctrl.sv
module rxfe_csr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic swrst_bit,
    input  logic ctrl_rd,
    input  logic err_evt,
    output logic restore,
    output logic rst_flag,
    output logic err_flag
);

    typedef struct packed {
        logic pend;
        logic rst_flag;
        logic err_flag;
    } ctrl_t;

    localparam ctrl_t CTRL_POR = '{pend: 1'b0, rst_flag: 1'b1, err_flag: 1'b0};

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.pend = ctrl_wr && swrst_bit;
        if (ctrl_rd) begin
            c_d.rst_flag = 1'b0;
            c_d.err_flag = 1'b0;
        end
        // set events win over a clear in the same cycle
        if (c_q.pend) c_d.rst_flag = 1'b1;
        if (err_evt)  c_d.err_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CTRL_POR;
        else        c_q <= c_d;
    end

    assign restore  = c_q.pend;
    assign rst_flag = c_q.rst_flag;
    assign err_flag = c_q.err_flag;

endmodule

// File: rtl/rxfe_csr_bank.sv
module rxfe_csr_bank
    import rxfe_csr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int STD_W    = 12,
    parameter int LVL_W    = 10,
    parameter int REF_W    = 9,
    parameter int TOP_W    = 4,
    parameter int PORT_W   = 6,
    parameter int NUM_COEF = 4,
    parameter int COEF_W   = 9,
    parameter int GAIN_W   = 11,
    parameter int TUNER_W  = 12,
    parameter int FREQ_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strap_hi,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       err_evt,
    input  logic [GAIN_W-1:0]          st_gain,
    input  logic [TUNER_W-1:0]         st_tuner,
    input  logic [GAIN_W-1:0]          st_sif,
    input  logic [FREQ_W-1:0]          st_freq,
    input  logic                       st_lock,
    input  logic [GAIN_W-1:0]          st_qual,
    output logic [STD_W-1:0]           std_sel,
    output logic [LVL_W-1:0]           lvl_cfg,
    output logic [REF_W-1:0]           ref_div,
    output logic [TOP_W-1:0]           top_gain,
    output logic [NUM_COEF*COEF_W-1:0] coef_active,
    output logic [PORT_W-1:0]          port_pins
);

    localparam int FLAG_RST = DATA_W - 1;
    localparam int FLAG_ERR = DATA_W - 2;

    typedef struct packed {
        logic [STD_W-1:0]  std;
        logic [LVL_W-1:0]  lvl;
        logic [REF_W-1:0]  refdiv;
        logic [TOP_W-1:0]  top;
        logic [PORT_W-1:0] port;
    } cfg_t;

    wsel_t               wsel;
    logic [NUM_COEF-1:0] coef_sel;
    rsel_e               rsel;
    logic                restore;
    logic                rst_flag_q;
    logic                err_flag_q;
    cfg_t                cfg_d, cfg_q;
    logic                unused_wbits;

    assign unused_wbits = ^wdata[FLAG_ERR:COEF_W+1];

    function automatic cfg_t cfg_default(input logic strap);
        cfg_t c;
        c.std    = STD_W'(DEF_STD);
        c.lvl    = LVL_W'(DEF_LVL);
        c.refdiv = strap ? REF_W'(DEF_REF_HIGH) : REF_W'(DEF_REF_LOW);
        c.top    = TOP_W'(DEF_TOP);
        c.port   = PORT_W'(DEF_PORT);
        return c;
    endfunction

    rxfe_csr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_COEF (NUM_COEF)
    ) u_decode (
        .addr     (addr),
        .wsel     (wsel),
        .coef_sel (coef_sel),
        .rsel     (rsel)
    );

    rxfe_csr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_en && wsel.ctrl),
        .swrst_bit (wdata[FLAG_RST]),
        .ctrl_rd   (rd_en && (rsel == RSEL_CTRL)),
        .err_evt   (err_evt),
        .restore   (restore),
        .rst_flag  (rst_flag_q),
        .err_flag  (err_flag_q)
    );

    rxfe_csr_coef #(
        .NUM_COEF (NUM_COEF),
        .COEF_W   (COEF_W)
    ) u_coef (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore     (restore),
        .wr_en       (wr_en),
        .coef_sel    (coef_sel),
        .wval        (wdata[COEF_W:0]),
        .coef_active (coef_active)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (restore) begin
            cfg_d = cfg_default(strap_hi);
        end else if (wr_en) begin
            if (wsel.std)    cfg_d.std    = wdata[STD_W-1:0];
            if (wsel.lvl)    cfg_d.lvl    = wdata[LVL_W-1:0];
            if (wsel.refdiv) cfg_d.refdiv = wdata[REF_W-1:0];
            if (wsel.top)    cfg_d.top    = wdata[TOP_W-1:0];
            if (wsel.port)   cfg_d.port   = wdata[PORT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_default(strap_hi);
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            RSEL_CTRL: begin
                rdata[FLAG_RST] = rst_flag_q;
                rdata[FLAG_ERR] = err_flag_q;
            end
            RSEL_GAIN:  rdata[GAIN_W-1:0]  = st_gain;
            RSEL_TUNER: rdata[TUNER_W-1:0] = st_tuner;
            RSEL_SIF:   rdata[GAIN_W-1:0]  = st_sif;
            RSEL_FREQ: begin
                rdata[FREQ_W:1] = st_freq;
                rdata[0]        = st_lock;
            end
            RSEL_QUAL:  rdata[GAIN_W-1:0]  = st_qual;
            default:    rdata = '0;
        endcase
    end

    assign std_sel   = cfg_q.std;
    assign lvl_cfg   = cfg_q.lvl;
    assign ref_div   = cfg_q.refdiv;
    assign top_gain  = cfg_q.top;
    assign port_pins = cfg_q.port;

endmodule

// File: rtl/rxfe_csr_bank_chk.sv
module rxfe_csr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        strap_hi,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] addr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        err_evt,
    input logic        restore,
    input logic        rst_flag_q,
    input logic        err_flag_q,
    input logic [11:0] std_sel,
    input logic [3:0]  top_gain,
    input logic [8:0]  ref_div,
    input logic [35:0] coef_active,
    input logic [5:0]  port_pins
);

    logic readable;
    assign readable = (addr == 16'h0000) || (addr == 16'h1005) || (addr == 16'h1006) ||
                      (addr == 16'h100A) || (addr == 16'h100B) || (addr == 16'h100C);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 16'h0000 && !restore && !err_evt) |=> (!rst_flag_q && !err_flag_q));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_flag_q);

    a_r5_restore_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (std_sel == 12'h103 && top_gain == 4'h3 && port_pins == 6'h00 && rst_flag_q));

    a_r2_strap_divider: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (ref_div == ($past(strap_hi) ? 9'h10D : 9'h0CA)));

    a_r7_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == 16'h0003) && !restore) |=> $stable(port_pins));

    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == 16'h1070 && wdata[0]) && !restore) |=> $stable(coef_active));

    a_r10_unreadable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !readable |-> (rdata == 16'h0000));

endmodule

bind rxfe_csr_bank rxfe_csr_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_hi    (strap_hi),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .err_evt     (err_evt),
    .restore     (restore),
    .rst_flag_q  (rst_flag_q),
    .err_flag_q  (err_flag_q),
    .std_sel     (std_sel),
    .top_gain    (top_gain),
    .ref_div     (ref_div),
    .coef_active (coef_active),
    .port_pins   (port_pins)
);

// File: tb/rxfe_csr_bank_test.sv
`timescale 1ns/1ps
module rxfe_csr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hi = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        err_evt = 1'b0;
    logic [10:0] st_gain = 11'h0;
    logic [11:0] st_tuner = 12'h0;
    logic [10:0] st_sif = 11'h0;
    logic [7:0]  st_freq = 8'h0;
    logic        st_lock = 1'b0;
    logic [10:0] st_qual = 11'h0;
    logic [11:0] std_sel;
    logic [9:0]  lvl_cfg;
    logic [8:0]  ref_div;
    logic [3:0]  top_gain;
    logic [35:0] coef_active;
    logic [5:0]  port_pins;

    int total = 0;
    int bad = 0;

    logic [11:0] e_std;
    logic [9:0]  e_lvl;
    logic [8:0]  e_ref;
    logic [3:0]  e_top;
    logic [5:0]  e_port;
    logic [8:0]  e_act [4];

    always #4 clk = ~clk;

    rxfe_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err_evt(err_evt),
        .st_gain(st_gain), .st_tuner(st_tuner), .st_sif(st_sif), .st_freq(st_freq),
        .st_lock(st_lock), .st_qual(st_qual), .std_sel(std_sel), .lvl_cfg(lvl_cfg),
        .ref_div(ref_div), .top_gain(top_gain), .coef_active(coef_active),
        .port_pins(port_pins)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_defaults(input logic strap);
        e_std = 12'h103; e_lvl = 10'h000; e_top = 4'h3; e_port = 6'h00;
        e_ref = strap ? 9'h10D : 9'h0CA;
        e_act[0] = 9'h025; e_act[1] = 9'h197; e_act[2] = 9'h0C5; e_act[3] = 9'h12E;
    endtask

    task automatic chk_outputs(input string tag);
        chk({tag, " std_sel"}, 32'(std_sel), 32'(e_std));
        chk({tag, " lvl_cfg"}, 32'(lvl_cfg), 32'(e_lvl));
        chk({tag, " ref_div"}, 32'(ref_div), 32'(e_ref));
        chk({tag, " top_gain"}, 32'(top_gain), 32'(e_top));
        chk({tag, " port_pins"}, 32'(port_pins), 32'(e_port));
        for (int i = 0; i < 4; i++)
            chk({tag, " coef_active"}, 32'(coef_active[i*9 +: 9]), 32'(e_act[i]));
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] exp_rd(input logic [15:0] a);
        case (a)
            16'h1005: exp_rd = {5'b0, st_gain};
            16'h1006: exp_rd = {4'b0, st_tuner};
            16'h100A: exp_rd = {5'b0, st_sif};
            16'h100B: exp_rd = {7'b0, st_freq, st_lock};
            16'h100C: exp_rd = {5'b0, st_qual};
            default:  exp_rd = 16'h0000;
        endcase
    endfunction

    function automatic logic is_wmapped(input logic [15:0] a);
        return (a == 16'h0000) || (a == 16'h0003) || (a == 16'h0020) || (a == 16'h1001) ||
               (a == 16'h1010) || (a == 16'h1012) || (a >= 16'h1070 && a <= 16'h1073);
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 reset state with strap high
        set_defaults(1'b1);
        chk_outputs("R1 R2 reset");
        rd(16'h0000, v); chk("R3 power-on flag", 32'(v), 32'h8000);
        rd(16'h0000, v); chk("R4 flag cleared by read", 32'(v), 32'h0000);

        // R6 register writes, upper bits dropped
        wr(16'h0020, 16'hF456); e_std = 12'h456;
        wr(16'h1001, 16'hFFFF); e_lvl = 10'h3FF;
        wr(16'h1010, 16'hABCD); e_ref = 9'h1CD;
        wr(16'h1012, 16'h00F7); e_top = 4'h7;
        chk_outputs("R6 writes");

        // R7 port sweep
        for (int p = 0; p < 64; p++) begin
            wr(16'h0003, {10'h3A5, 6'(p)});
            chk("R7 port pins", 32'(port_pins), 32'(p));
        end
        e_port = 6'h3F;
        rd(16'h0003, v); chk("R7 port not readable", 32'(v), 32'h0);

        // R8 staging and commit
        wr(16'h1071, 16'h01AA);
        wr(16'h1072, 16'hFE11);
        wr(16'h1073, 16'h0022);
        wr(16'h1070, 16'h01E0);
        chk_outputs("R8 staged only");
        wr(16'h1070, 16'h02AB);
        e_act[0] = 9'h155; e_act[1] = 9'h1AA; e_act[2] = 9'h011; e_act[3] = 9'h022;
        chk_outputs("R8 commit");
        wr(16'h1071, 16'hFFFF);
        chk_outputs("R8 stage after commit");
        wr(16'h1070, 16'h0003);
        e_act[0] = 9'h001; e_act[1] = 9'h1FF;
        chk_outputs("R8 second commit");

        // R3 / R4 error flag
        err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
        rd(16'h0000, v); chk("R3 error flag", 32'(v), 32'h4000);
        rd(16'h0000, v); chk("R4 error cleared", 32'(v), 32'h0000);
        err_evt = 1'b1;
        rd(16'h0000, v); chk("R4 same-cycle read", 32'(v), 32'h0000);
        err_evt = 1'b0;
        rd(16'h0000, v); chk("R4 set wins over clear", 32'(v), 32'h4000);
        rd(16'h0000, v); chk("R4 cleared again", 32'(v), 32'h0000);

        // R9 / R10 / R11 read sweep of the whole space
        st_gain = 11'h5A5; st_tuner = 12'hC3C; st_sif = 11'h2DB;
        st_freq = 8'h96; st_lock = 1'b1; st_qual = 11'h7E1;
        for (int a = 0; a < 65536; a++) begin
            addr = 16'(a);
            #1 chk("R9 R10 R11 read sweep", 32'(rdata), 32'(exp_rd(16'(a))));
            @(negedge clk);
        end
        st_gain = 11'h25A; st_tuner = 12'h3C3; st_sif = 11'h524;
        st_freq = 8'h69; st_lock = 1'b0; st_qual = 11'h01E;
        foreach (exp_rd_list[k]) begin end
        addr = 16'h1005; #1 chk("R9 gain", 32'(rdata), 32'h025A); @(negedge clk);
        addr = 16'h1006; #1 chk("R9 tuner", 32'(rdata), 32'h03C3); @(negedge clk);
        addr = 16'h100A; #1 chk("R9 sif", 32'(rdata), 32'h0524); @(negedge clk);
        addr = 16'h100B; #1 chk("R9 freq lock", 32'(rdata), 32'h00D2); @(negedge clk);
        addr = 16'h100C; #1 chk("R9 quality", 32'(rdata), 32'h001E); @(negedge clk);

        // R10 writes to unmapped and status addresses ignored
        for (int a = 0; a < 512; a++) begin
            logic [15:0] wa;
            wa = (a < 256) ? 16'(a) : 16'(16'h1000 + a - 256);
            if (!is_wmapped(wa)) wr(wa, 16'hFFFF);
        end
        chk_outputs("R10 unmapped writes");
        rd(16'h0000, v); chk("R10 flags untouched", 32'(v), 32'h0000);

        // R5 software reset
        wr(16'h0000, 16'h7FFF);
        @(negedge clk);
        chk_outputs("R5 bit15 clear no effect");
        rd(16'h0000, v); chk("R5 no reset flag", 32'(v), 32'h0000);
        strap_hi = 1'b0;
        wr(16'h0000, 16'h8000);
        wr(16'h0020, 16'h0ABC);
        set_defaults(1'b0);
        chk_outputs("R5 R2 soft reset strap low");
        rd(16'h0000, v); chk("R5 reset flag set", 32'(v), 32'h8000);
        rd(16'h0000, v); chk("R5 reset flag cleared", 32'(v), 32'h0000);

        finish_run();
    end

    logic exp_rd_list [1];

endmodule